// File: doc/BRIEF.md
# Circular Queue-Head Schedule Walker

This block runs the host-side asynchronous schedule, which is kept in memory as a ring of queue heads. Software writes the address of one queue head into the list address register and then sets the enable bit. On the next micro-frame start, the walker begins a pass. It reads the head at the list address through a request/valid read port, then follows the head's horizontal link to the next head, and so on. For every head it visits, it emits a service pulse carrying that head's address and its work flag. The status bit reports to software whether the schedule is actually running.

A pass stops on any of three events: a micro-frame end pulse, an empty ring, or software clearing the enable bit. The ring is empty when the walker goes once around the whole ring and finds no head with its work flag set. After each visit, the list address register takes the link of the head just visited. The next pass therefore resumes where the last one stopped, so the heads are served in round-robin order.

Software writes one of two registers. The control word (select 0) holds the enable bit in bit 0. The list address word (select 1) holds the ring address. The walker has three states. WK_OFF means the schedule is stopped. WK_WAIT means the schedule is running and waiting for a micro-frame start. WK_FETCH means a read is outstanding. The transitions are:
- start_up (WK_OFF to WK_FETCH): enable is set and a micro-frame start arrives.
- next_frame (WK_WAIT to WK_FETCH): enable is set and a micro-frame start arrives.
- pass_end (WK_FETCH to WK_WAIT): read data returns and the ring is empty, or a stop is pending.
- shut_down (WK_WAIT to WK_OFF): enable is clear.

Top module: `qh_ring_walker`

## Requirements
- R1: After reset, the following are all zero: enable, status, error flag, list address and read request.
- R2: A write with select 0 loads bit 0 of the data into the enable bit, provided enable equals status at the time of the write.
- R3: A write with select 0 while enable differs from status leaves enable unchanged and sets the error flag. The error flag is sticky and only reset clears it.
- R4: A write with select 1 loads the list address with bits 4:0 forced to zero. This happens only while enable and status are both zero; at any other time the write is ignored.
- R5: Status stays zero after enable is set. It rises on the clock edge that takes the first micro-frame start while enable is one, and that same edge begins a pass.
- R6: A pass first reads the head at the list address, then the head named by each fetched link, with link bits 4:0 forced to zero. Each visited head gives one service pulse, with the head's address and its work flag.
- R7: A micro-frame end pulse during a pass ends the pass once the outstanding read returns. That last head is still visited. The list address then holds the last visited head's link, and the next pass begins at that head.
- R8: If the walker goes once round the ring without a set work flag, it stops after visiting each head exactly once. The list address is left at the pass's starting head, and status stays one.
- R9: Clearing enable ends the pass after the outstanding read, and status then falls once the walker is idle.
- R10: While a read is requested and no data has returned, the request stays high and the read address does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 control, 1 list address |
| cfg_wdata | input | 32 | Write data |
| sched_en | output | 1 | Enable bit |
| sched_sts | output | 1 | Status bit (schedule running) |
| list_addr | output | 32 | List address register / resume point |
| seq_err | output | 1 | Sticky illegal-enable-write flag |
| uf_start | input | 1 | Micro-frame start pulse |
| uf_end | input | 1 | Micro-frame end pulse |
| mem_req | output | 1 | Read request |
| mem_addr | output | 32 | Read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rlink | input | 32 | Fetched horizontal link |
| mem_ractive | input | 1 | Fetched work flag |
| svc_pulse | output | 1 | One-cycle service pulse per visited head |
| svc_addr | output | 32 | Address of the visited head |
| svc_work | output | 1 | Work flag of the visited head |

## Verification
The walk is swept over rings of one to five heads, trying every work-flag pattern for each ring size, with read latency changing as the ring size changes. The all-clear pattern separates empty-ring detection (exactly one lap, resume point unchanged) from a walk that keeps going. Every other pattern is cut off by a micro-frame end after a run length that varies, and each next pass must pick up at the head following the last one served. This separates real round-robin resume from a restart at the first head. Control writes made while enable and status differ, and list address writes made while running, check the handshake rules separately from the walk itself.

// File: rtl/qhw_pkg.sv
package qhw_pkg;
    typedef enum logic [1:0] {
        WK_OFF   = 2'd0,
        WK_WAIT  = 2'd1,
        WK_FETCH = 2'd2
    } wk_state_t;

    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_LIST = 1'b1;
endpackage

// File: rtl/qhw_regs.sv
module qhw_regs
    import qhw_pkg::*;
#(
    parameter int AW = 32,
    parameter int AB = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [AW-1:0] wr_data,
    input  logic          sts,
    input  logic          adv,
    input  logic [AW-1:0] adv_ptr,
    output logic          en,
    output logic          err,
    output logic [AW-1:0] list_addr
);
    localparam logic [AB-1:0] LOW_ZERO = '0;

    logic ctrl_wr, list_wr, handshake_ok;

    assign ctrl_wr      = wr_en && (wr_sel == SEL_CTRL);
    assign list_wr      = wr_en && (wr_sel == SEL_LIST);
    assign handshake_ok = (en == sts);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en  <= 1'b0;
            err <= 1'b0;
        end else if (ctrl_wr) begin
            if (handshake_ok) en  <= wr_data[0];
            else              err <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            list_addr <= '0;
        end else if (adv) begin
            list_addr <= adv_ptr;
        end else if (list_wr && !en && !sts) begin
            list_addr <= {wr_data[AW-1:AB], LOW_ZERO};
        end
    end
endmodule

// File: rtl/qhw_walker.sv
module qhw_walker
    import qhw_pkg::*;
#(
    parameter int AW = 32,
    parameter int AB = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [AW-1:0] list_addr,
    input  logic          uf_start,
    input  logic          uf_end,
    input  logic          rvalid,
    input  logic [AW-1:0] rlink,
    input  logic          ractive,
    output logic          sts,
    output logic          mem_req,
    output logic          adv,
    output logic [AW-1:0] adv_ptr,
    output logic          svc_pulse,
    output logic          svc_work
);
    localparam logic [AB-1:0] LOW_ZERO = '0;

    wk_state_t     state, state_nx;
    logic [AW-1:0] marker;
    logic          lap_work, first_q, stop_q;
    logic          at_mark, ring_empty, halt, pass_start, visit;

    assign at_mark    = (list_addr == marker) && !first_q;
    assign ring_empty = at_mark && !lap_work;
    assign halt       = stop_q || uf_end || !en;
    assign pass_start = (state != WK_FETCH) && (state_nx == WK_FETCH);
    assign visit      = (state == WK_FETCH) && rvalid && !ring_empty;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= WK_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            WK_OFF:   if (en && uf_start) state_nx = WK_FETCH;
            WK_WAIT: begin
                if (!en)          state_nx = WK_OFF;
                else if (uf_start) state_nx = WK_FETCH;
            end
            WK_FETCH: if (rvalid && (ring_empty || halt)) state_nx = WK_WAIT;
            default:  state_nx = WK_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            marker   <= '0;
            lap_work <= 1'b0;
            first_q  <= 1'b0;
            stop_q   <= 1'b0;
        end else if (pass_start) begin
            marker   <= list_addr;
            lap_work <= 1'b0;
            first_q  <= 1'b1;
            stop_q   <= 1'b0;
        end else if (state == WK_FETCH) begin
            if (uf_end || !en) stop_q <= 1'b1;
            if (visit) begin
                first_q  <= 1'b0;
                lap_work <= at_mark ? ractive : (lap_work | ractive);
            end
        end
    end

    always_comb begin
        sts       = (state != WK_OFF);
        mem_req   = (state == WK_FETCH);
        adv       = visit;
        adv_ptr   = {rlink[AW-1:AB], LOW_ZERO};
        svc_pulse = visit;
        svc_work  = ractive;
    end
endmodule

// File: rtl/qh_ring_walker.sv
module qh_ring_walker
    import qhw_pkg::*;
#(
    parameter int AW = 32,
    parameter int AB = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic          sched_en,
    output logic          sched_sts,
    output logic [AW-1:0] list_addr,
    output logic          seq_err,
    input  logic          uf_start,
    input  logic          uf_end,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [AW-1:0] mem_rlink,
    input  logic          mem_ractive,
    output logic          svc_pulse,
    output logic [AW-1:0] svc_addr,
    output logic          svc_work
);
    logic          adv;
    logic [AW-1:0] adv_ptr;

    qhw_regs #(.AW(AW), .AB(AB)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we), .wr_sel(cfg_sel), .wr_data(cfg_wdata),
        .sts(sched_sts), .adv(adv), .adv_ptr(adv_ptr),
        .en(sched_en), .err(seq_err), .list_addr(list_addr)
    );

    qhw_walker #(.AW(AW), .AB(AB)) walk_i (
        .clk(clk), .rst_n(rst_n),
        .en(sched_en), .list_addr(list_addr),
        .uf_start(uf_start), .uf_end(uf_end),
        .rvalid(mem_rvalid), .rlink(mem_rlink), .ractive(mem_ractive),
        .sts(sched_sts), .mem_req(mem_req),
        .adv(adv), .adv_ptr(adv_ptr),
        .svc_pulse(svc_pulse), .svc_work(svc_work)
    );

    assign mem_addr = list_addr;
    assign svc_addr = list_addr;
endmodule

// File: rtl/qhw_checker.sv
module qhw_checker #(
    parameter int AW = 32,
    parameter int AB = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic          cfg_sel,
    input logic          sched_en,
    input logic          sched_sts,
    input logic [AW-1:0] list_addr,
    input logic          seq_err,
    input logic          uf_start,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rvalid,
    input logic          svc_pulse
);
    a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    a_r5_sts_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!sched_sts && !(sched_en && uf_start)) |=> !sched_sts);

    a_r3_illegal_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_sel && (sched_en != sched_sts)) |=>
            (seq_err && (sched_en == $past(sched_en))));

    a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> seq_err);

    a_r4_list_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel && (sched_en || sched_sts) && !mem_rvalid) |=>
            $stable(list_addr));

    a_r4_align: assert property (@(posedge clk) disable iff (!rst_n)
        list_addr[AB-1:0] == '0);

    a_r9_sts_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (sched_sts && !sched_en && !mem_req) |=> !sched_sts);

    a_r6_svc_running: assert property (@(posedge clk) disable iff (!rst_n)
        svc_pulse |-> (sched_sts && mem_req && mem_rvalid));
endmodule

bind qh_ring_walker qhw_checker #(.AW(AW), .AB(AB)) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .sched_en(sched_en), .sched_sts(sched_sts), .list_addr(list_addr),
    .seq_err(seq_err), .uf_start(uf_start), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .svc_pulse(svc_pulse)
);

// File: tb/qh_ring_walker_tb_top.sv
module qh_ring_walker_tb_top;
    localparam logic [31:0] BASE = 32'h0000_2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        sched_en, sched_sts, seq_err;
    logic [31:0] list_addr, mem_addr, svc_addr;
    logic        uf_start = 1'b0, uf_end = 1'b0;
    logic        mem_req, svc_pulse, svc_work;
    logic        mem_rvalid;
    logic [31:0] mem_rlink;
    logic        mem_ractive;

    always #5 clk = ~clk;

    qh_ring_walker dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .sched_en(sched_en), .sched_sts(sched_sts),
        .list_addr(list_addr), .seq_err(seq_err), .uf_start(uf_start),
        .uf_end(uf_end), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rlink(mem_rlink),
        .mem_ractive(mem_ractive), .svc_pulse(svc_pulse),
        .svc_addr(svc_addr), .svc_work(svc_work)
    );

    int nvec = 0, nerr = 0;
    int nheads = 1, lat = 1;
    logic [31:0] act_pat = '0;
    bit done = 0;

    // memory model: ring of nheads heads, BASE + i*32, junk in link low bits
    logic        busy;
    int          cnt;
    logic [31:0] cap_addr;
    always @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; cnt <= 0; mem_rvalid <= 1'b0;
            mem_rlink <= '0; mem_ractive <= 1'b0; cap_addr <= '0;
        end else begin
            mem_rvalid <= 1'b0;
            if (busy) begin
                if (cnt <= 1) begin
                    int idx;
                    idx = int'((cap_addr - BASE) >> 5);
                    mem_rvalid  <= 1'b1;
                    mem_rlink   <= (BASE + 32'((((idx + 1) % nheads)) * 32)) | 32'h13;
                    mem_ractive <= act_pat[idx];
                    busy <= 1'b0;
                end else cnt <= cnt - 1;
            end else if (mem_req && !mem_rvalid) begin
                busy <= 1'b1; cnt <= lat; cap_addr <= mem_addr;
            end
        end
    end

    logic [31:0] rec_addr [256];
    logic        rec_work [256];
    int          svc_n = 0;
    always @(negedge clk) begin
        if (svc_pulse && svc_n < 256) begin
            rec_addr[svc_n] = svc_addr;
            rec_work[svc_n] = svc_work;
            svc_n++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); uf_start = 1'b1;
        @(negedge clk); uf_start = 1'b0;
    endtask

    task automatic pulse_end();
        @(negedge clk); uf_end = 1'b1;
        @(negedge clk); uf_end = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400 && mem_req; i++) @(negedge clk);
    endtask

    task automatic wait_off();
        for (int i = 0; i < 400 && sched_sts; i++) @(negedge clk);
    endtask

    function automatic logic [31:0] hadr(input int i);
        return BASE + 32'(i * 32);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        int s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(sched_en == 0, "R1 enable", 32'(sched_en), 0);
        chk(sched_sts == 0, "R1 status", 32'(sched_sts), 0);
        chk(seq_err == 0, "R1 error", 32'(seq_err), 0);
        chk(list_addr == 0, "R1 list", list_addr, 0);
        chk(mem_req == 0, "R1 req", 32'(mem_req), 0);

        for (int n = 1; n <= 5; n++) begin
            nheads = n;
            lat = 1 + (n % 3);
            if (sched_en) begin
                wait_idle();
                wr(1'b0, 32'h0);
                wait_off();
                chk(sched_sts == 0, "R9 status falls", 32'(sched_sts), 0);
            end
            wr(1'b1, BASE | 32'h1B);
            chk(list_addr == BASE, "R4 aligned list write", list_addr, BASE);
            wr(1'b0, 32'h1);
            chk(sched_en == 1, "R2 enable set", 32'(sched_en), 1);
            repeat (3) @(negedge clk);
            chk(sched_sts == 0, "R5 status waits for start", 32'(sched_sts), 0);
            s = 0;
            for (int p = 0; p < (1 << n); p++) begin
                act_pat = 32'(p);
                svc_n = 0;
                pulse_start();
                chk(sched_sts == 1, "R5 status up", 32'(sched_sts), 1);
                if (p == 0) begin
                    wait_idle();
                    chk(svc_n == n, "R8 one lap visits", 32'(svc_n), 32'(n));
                    chk(list_addr == hadr(s), "R8 list unchanged", list_addr, hadr(s));
                    chk(sched_sts == 1, "R8 status held", 32'(sched_sts), 1);
                end else begin
                    repeat (10 + 3 * p) @(negedge clk);
                    pulse_end();
                    wait_idle();
                    chk(svc_n >= 1, "R7 visits before end", 32'(svc_n), 1);
                    for (int k = 0; k < svc_n; k++) begin
                        int ei;
                        ei = (s + k) % n;
                        chk(rec_addr[k] == hadr(ei), "R6 visit order", rec_addr[k], hadr(ei));
                        chk(rec_work[k] == act_pat[ei], "R6 work flag", 32'(rec_work[k]), 32'(act_pat[ei]));
                    end
                    s = (s + svc_n) % n;
                    chk(list_addr == hadr(s), "R7 resume point", list_addr, hadr(s));
                end
            end
        end

        // R4: list write ignored while running (en=1, sts=1, idle between frames)
        begin
            logic [31:0] save;
            save = list_addr;
            wr(1'b1, 32'h0000_8000);
            chk(list_addr == save, "R4 list write ignored", list_addr, save);
        end

        // R3 / R9: disable mid-pass, then illegal re-enable
        act_pat = 32'h1F;
        pulse_start();
        repeat (2) @(negedge clk);
        wr(1'b0, 32'h0);
        chk(sched_en == 0, "R2 enable cleared", 32'(sched_en), 0);
        chk(sched_sts == 1, "R9 status lags", 32'(sched_sts), 1);
        wr(1'b0, 32'h1);
        chk(sched_en == 0, "R3 enable unchanged", 32'(sched_en), 0);
        chk(seq_err == 1, "R3 error set", 32'(seq_err), 1);
        wait_off();
        chk(sched_sts == 0, "R9 status falls", 32'(sched_sts), 0);
        chk(mem_req == 0, "R9 no request", 32'(mem_req), 0);
        pulse_start();
        chk(sched_sts == 0, "R5 no start when disabled", 32'(sched_sts), 0);
        chk(seq_err == 1, "R3 error sticky", 32'(seq_err), 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule